// File: doc/BRIEF.md
# Light-Load Burst Supervisor

This block sits beside the normal switching path of a quasi-resonant flyback controller. It watches a set of digital flags from the feedback comparators and the present valley count. From these it decides when the converter drops into burst operation at light load and when it returns to normal switching. While burst is active, the block produces the gate pulses itself, using a fixed-rate timer.

Entry into burst needs two conditions at once: feedback below the entry level, and the valley counter at its ceiling. Both must then stay true, without a break, for a blanking interval. Inside burst, a hysteresis band on the feedback turns the switching section on and off.

- Each pulse starts at the beginning of a timer period.
- A pulse ends at half the period, or earlier if the burst current limit trips.
- A stretch of switching that has begun always completes its current period before it halts.

A large feedback rise ends burst. On exit the block emits a one-cycle pulse that loads the valley counter with 1. The burst-active output also serves as the mask for the overload, over-temperature and short-winding protections.

Top module: `burst_supervisor`

## Requirements
- R1: During and after reset, `burst_active`, `burst_gate` and `valley_set_one` are 0 and `pwm_enable` is 1.
- R2: `burst_active` rises at the BLANK_CYC-th consecutive rising edge at which the entry conditions are sampled true. The conditions are `fb_enter_low`=1 and `valley_cnt`=VALLEY_MAX (7 by default).
- R3: If either entry condition is sampled false before the blanking count completes, the count restarts from zero. A fresh run of BLANK_CYC consecutive qualifying edges is then needed.
- R4: On entering burst, switching stays idle (`pwm_enable`=0, `burst_gate`=0) until `fb_burst_on` is sampled high.
- R5: `fb_burst_on` sampled high in idle burst sets `pwm_enable` from the next cycle.
  - Each PERIOD_CYC-cycle period then begins with `burst_gate` high.
  - The gate stays high for at most PERIOD_CYC/2 cycles (phases 0 to PERIOD_CYC/2-1).
- R6: `cs_trip` sampled high while `burst_gate` is high drives the gate low from the next cycle to the end of that period. The following period starts a new pulse.
- R7: `fb_burst_off` sampled high while switching stops switching only at the end of the current period. `pwm_enable` and the gate fall after the period's last cycle, and no pulse is cut short.
- R8: When `fb_leave` is sampled high in burst, the following happen in the next cycle:
  - `burst_active` falls and `burst_gate` is 0.
  - `pwm_enable` is 1.
  - `valley_set_one` is high for exactly that one cycle.
- R9: Outside burst, `fb_burst_on`, `fb_burst_off`, `fb_leave` and `cs_trip` have no effect: the gate stays 0 and no valley pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_enter_low | input | 1 | Feedback below the burst entry level |
| fb_burst_off | input | 1 | Feedback at or below the lower hysteresis level |
| fb_burst_on | input | 1 | Feedback above the upper hysteresis level |
| fb_leave | input | 1 | Feedback above the burst exit level |
| cs_trip | input | 1 | Sensed current reached the burst limit |
| valley_cnt | input | VALLEY_W | Present valley counter value |
| burst_active | output | 1 | Burst operation active; also masks the protections |
| burst_gate | output | 1 | Gate drive generated in burst |
| pwm_enable | output | 1 | Switching section enabled |
| valley_set_one | output | 1 | One-cycle pulse that loads the valley counter with 1 |

## Verification
The assertions check the following properties on every cycle:
- The gate is never high outside an enabled burst stretch.
- No gate pulse lasts longer than half a period.
- A trip holds the gate low for the rest of its period.
- Switching halts only at a period boundary.
- Every rise of `burst_active` was preceded by both entry conditions.
- Every exit carries a single-cycle valley pulse.

Only the bench scenarios can show the rest:
- The exact blanking length and its restart after an interrupted condition.
- The position of gate pulses within the period.
- That inputs outside burst are ignored.

// File: rtl/burst_pkg.sv
// Shared types for the burst supervisor.
package burst_pkg;
    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_BURST  = 1'b1
    } mode_e;
endpackage

// File: rtl/burst_entry_blank.sv
// Entry qualifier: counts consecutive edges at which the feedback is low and
// the valley count sits at its ceiling. It requests entry on the
// BLANK_CYC-th such edge.
// Assumes: inputs are synchronous, and the count is held at zero while in burst.
module burst_entry_blank #(
    parameter int BLANK_CYC  = 20,
    parameter int VALLEY_W   = 3,
    parameter int VALLEY_MAX = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fb_enter_low,
    input  logic [VALLEY_W-1:0] valley_cnt,
    input  logic                in_burst,
    output logic                enter_req
);
    localparam int CNT_W = $clog2(BLANK_CYC + 1);
    localparam logic [CNT_W-1:0]    LAST = CNT_W'(BLANK_CYC - 1);
    localparam logic [VALLEY_W-1:0] VMAX = VALLEY_W'(VALLEY_MAX);

    logic [CNT_W-1:0] cnt_q;
    logic             cond;

    // Both entry conditions hold, and the block is not already in burst.
    assign cond      = fb_enter_low && (valley_cnt == VMAX) && !in_burst;
    assign enter_req = cond && (cnt_q == LAST);

    // Blanking counter: restarts whenever the condition breaks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!cond) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/burst_mode_ctrl.sv
// Mode controller: tracks normal/burst mode and the switching-run flag
// inside burst (hysteresis band). It issues the valley reset pulse on exit.
// Assumes: period_end comes from the timer and is high in the last cycle of a period.
module burst_mode_ctrl
    import burst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter_req,
    input  logic fb_burst_on,
    input  logic fb_burst_off,
    input  logic fb_leave,
    input  logic period_end,
    output logic in_burst,
    output logic run,
    output logic valley_set
);
    mode_e mode_q;
    logic  run_q;
    logic  stop_req_q;
    logic  vset_q;

    assign in_burst   = (mode_q == MODE_BURST);
    assign run        = run_q;
    assign valley_set = vset_q;

    // Mode, run flag, pending stop and exit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_NORMAL;
            run_q      <= 1'b0;
            stop_req_q <= 1'b0;
            vset_q     <= 1'b0;
        end else begin
            vset_q <= 1'b0;
            case (mode_q)
                MODE_NORMAL: begin
                    run_q      <= 1'b0;
                    stop_req_q <= 1'b0;
                    if (enter_req) mode_q <= MODE_BURST;
                end
                default: begin
                    if (fb_leave) begin
                        mode_q     <= MODE_NORMAL;
                        run_q      <= 1'b0;
                        stop_req_q <= 1'b0;
                        vset_q     <= 1'b1;
                    end else if (!run_q) begin
                        stop_req_q <= 1'b0;
                        if (fb_burst_on) run_q <= 1'b1;
                    end else if (period_end && (stop_req_q || fb_burst_off)) begin
                        run_q      <= 1'b0;
                        stop_req_q <= 1'b0;
                    end else if (fb_burst_off) begin
                        stop_req_q <= 1'b1;
                    end else if (fb_burst_on) begin
                        stop_req_q <= 1'b0;
                    end
                end
            endcase
        end
    end

    // The valley pulse lasts a single cycle (R8).
    assert_vset_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vset_q |=> !vset_q);

    // Switching only runs in burst mode (R5).
    assert_run_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (mode_q == MODE_BURST));
endmodule

// File: rtl/burst_pwm_timer.sv
// Fixed-rate pulse generator for burst switching. Each period opens with the
// gate high. The gate closes at half the period or one cycle after a
// current trip, whichever comes first.
// Assumes: run comes from a register, and PERIOD_CYC is even and at least 2.
module burst_pwm_timer #(
    parameter int PERIOD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cs_trip,
    output logic gate,
    output logic period_end
);
    localparam int PH_W = $clog2(PERIOD_CYC);
    localparam int HALF = PERIOD_CYC / 2;
    localparam logic [PH_W-1:0] LAST  = PH_W'(PERIOD_CYC - 1);
    localparam logic [PH_W-1:0] HALFV = PH_W'(HALF);

    logic [PH_W-1:0] phase_q;
    logic            trip_q;

    assign period_end = run && (phase_q == LAST);
    assign gate       = run && (phase_q < HALFV) && !trip_q;

    // Phase counter: wraps each period and parks at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Trip latch: holds the gate off until the period wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || period_end) begin
            trip_q <= 1'b0;
        end else if (gate && cs_trip) begin
            trip_q <= 1'b1;
        end
    end

    // Checker counter: length of the current gate-high stretch.
    logic [PH_W:0] hi_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !gate) hi_len_q <= '0;
        else                 hi_len_q <= hi_len_q + 1'b1;
    end

    assert_half_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hi_len_q <= (PH_W+1)'(HALF));

    assert_trip_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gate && cs_trip) && !$past(period_end)) |-> !gate);
endmodule

// File: rtl/burst_supervisor.sv
// Top of the light-load burst supervisor: combines the entry qualifier, the
// mode controller and the fixed-rate burst timer.
// Assumes: all threshold flags come from already synchronised comparator outputs.
module burst_supervisor #(
    parameter int PERIOD_CYC = 16,
    parameter int BLANK_CYC  = 20,
    parameter int VALLEY_W   = 3,
    parameter int VALLEY_MAX = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fb_enter_low,
    input  logic                fb_burst_off,
    input  logic                fb_burst_on,
    input  logic                fb_leave,
    input  logic                cs_trip,
    input  logic [VALLEY_W-1:0] valley_cnt,
    output logic                burst_active,
    output logic                burst_gate,
    output logic                pwm_enable,
    output logic                valley_set_one
);
    logic enter_req;
    logic run;
    logic period_end;

    burst_entry_blank #(
        .BLANK_CYC (BLANK_CYC),
        .VALLEY_W  (VALLEY_W),
        .VALLEY_MAX(VALLEY_MAX)
    ) u_entry (
        .clk         (clk),
        .rst_n       (rst_n),
        .fb_enter_low(fb_enter_low),
        .valley_cnt  (valley_cnt),
        .in_burst    (burst_active),
        .enter_req   (enter_req)
    );

    burst_mode_ctrl u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_req   (enter_req),
        .fb_burst_on (fb_burst_on),
        .fb_burst_off(fb_burst_off),
        .fb_leave    (fb_leave),
        .period_end  (period_end),
        .in_burst    (burst_active),
        .run         (run),
        .valley_set  (valley_set_one)
    );

    burst_pwm_timer #(
        .PERIOD_CYC(PERIOD_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cs_trip   (cs_trip),
        .gate      (burst_gate),
        .period_end(period_end)
    );

    // The switching section is on in normal mode, and in burst only while running.
    assign pwm_enable = !burst_active || run;

    assert_enter_conds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_active) |->
            ($past(fb_enter_low) && ($past(valley_cnt) == VALLEY_W'(VALLEY_MAX))));

    assert_exit_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(burst_active) |-> valley_set_one);

    assert_no_trunc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(run) && burst_active) |-> $past(period_end));

    assert_gate_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_gate |-> (burst_active && pwm_enable));
endmodule

// File: tb/burst_supervisor_tb.sv
// Directed bench for the burst supervisor: one task per scenario.
module burst_supervisor_tb;
    localparam int PER   = 8;
    localparam int HALF  = PER / 2;
    localparam int BLANK = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fb_enter_low = 1'b0, fb_burst_off = 1'b0, fb_burst_on = 1'b0;
    logic fb_leave = 1'b0, cs_trip = 1'b0;
    logic [2:0] valley_cnt = 3'd0;
    logic burst_active, burst_gate, pwm_enable, valley_set_one;
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    burst_supervisor #(.PERIOD_CYC(PER), .BLANK_CYC(BLANK)) u_dut (
        .clk(clk), .rst_n(rst_n), .fb_enter_low(fb_enter_low),
        .fb_burst_off(fb_burst_off), .fb_burst_on(fb_burst_on),
        .fb_leave(fb_leave), .cs_trip(cs_trip), .valley_cnt(valley_cnt),
        .burst_active(burst_active), .burst_gate(burst_gate),
        .pwm_enable(pwm_enable), .valley_set_one(valley_set_one));

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input logic act, input logic exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic go_burst();
        fb_enter_low = 1'b1; valley_cnt = 3'd7;
        repeat (BLANK) step();
        fb_enter_low = 1'b0; valley_cnt = 3'd3;
    endtask

    task automatic start_run();
        fb_burst_on = 1'b1; step(); fb_burst_on = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; repeat (3) step();
        chk(burst_active, 1'b0, "R1 active in reset");
        chk(burst_gate, 1'b0, "R1 gate in reset");
        chk(pwm_enable, 1'b1, "R1 enable in reset");
        rst_n = 1'b1; step();
        chk(valley_set_one, 1'b0, "R1 valley pulse after reset");
        chk(pwm_enable, 1'b1, "R1 enable after reset");
    endtask

    task automatic t_entry();
        fb_enter_low = 1'b1; valley_cnt = 3'd7;
        repeat (BLANK - 1) step();
        chk(burst_active, 1'b0, "R2 not yet at BLANK-1");
        step();
        chk(burst_active, 1'b1, "R2 entered at BLANK");
        fb_enter_low = 1'b0; valley_cnt = 3'd2;
        chk(pwm_enable, 1'b0, "R4 idle after entry");
        repeat (3) step();
        chk(burst_gate, 1'b0, "R4 gate idle");
        chk(pwm_enable, 1'b0, "R4 enable idle");
    endtask

    task automatic t_exit();
        fb_leave = 1'b1; step(); fb_leave = 1'b0;
        chk(burst_active, 1'b0, "R8 active falls");
        chk(valley_set_one, 1'b1, "R8 valley pulse");
        chk(pwm_enable, 1'b1, "R8 enable in normal");
        chk(burst_gate, 1'b0, "R8 gate low");
        step();
        chk(valley_set_one, 1'b0, "R8 pulse one cycle");
    endtask

    task automatic t_restart();
        fb_enter_low = 1'b1; valley_cnt = 3'd7;
        repeat (6) step();
        valley_cnt = 3'd6; step(); valley_cnt = 3'd7;
        repeat (BLANK - 1) step();
        chk(burst_active, 1'b0, "R3 restart after valley drop");
        step();
        chk(burst_active, 1'b1, "R3 entry after full restart");
        fb_enter_low = 1'b0;
        t_exit();
        fb_enter_low = 1'b1; valley_cnt = 3'd7;
        repeat (BLANK - 2) step();
        fb_enter_low = 1'b0; step(); fb_enter_low = 1'b1;
        repeat (BLANK - 1) step();
        chk(burst_active, 1'b0, "R3 restart after feedback drop");
        step();
        chk(burst_active, 1'b1, "R3 entry after feedback restart");
        fb_enter_low = 1'b0;
    endtask

    task automatic t_switching();
        start_run();
        chk(pwm_enable, 1'b1, "R5 enable after burst_on");
        for (int i = 0; i < 2 * PER; i++) begin
            chk(burst_gate, (i % PER) < HALF, $sformatf("R5 gate phase %0d", i));
            step();
        end
    endtask

    task automatic t_trip();
        step();
        cs_trip = 1'b1; step(); cs_trip = 1'b0;
        for (int p = 2; p < PER; p++) begin
            chk(burst_gate, 1'b0, $sformatf("R6 gate held low phase %0d", p));
            step();
        end
        chk(burst_gate, 1'b1, "R6 new pulse next period");
    endtask

    task automatic t_stop();
        step(); step();
        fb_burst_off = 1'b1; step(); fb_burst_off = 1'b0;
        chk(burst_gate, 1'b1, "R7 pulse not cut phase 3");
        for (int p = 3; p < PER; p++) begin
            chk(pwm_enable, 1'b1, $sformatf("R7 enable kept phase %0d", p));
            step();
        end
        chk(pwm_enable, 1'b0, "R7 stops at period end");
        chk(burst_gate, 1'b0, "R7 gate off after stop");
        repeat (4) step();
        chk(burst_gate, 1'b0, "R7 stays stopped");
    endtask

    task automatic t_exit_mid_pulse();
        start_run();
        step();
        chk(burst_gate, 1'b1, "R8 pulse before exit");
        t_exit();
    endtask

    task automatic t_ignored();
        fb_burst_on = 1'b1; cs_trip = 1'b1; step();
        chk(burst_gate, 1'b0, "R9 gate ignores burst_on");
        fb_burst_on = 1'b0; cs_trip = 1'b0; fb_leave = 1'b1; step(); fb_leave = 1'b0;
        chk(valley_set_one, 1'b0, "R9 no pulse on leave outside burst");
        fb_burst_off = 1'b1; step(); fb_burst_off = 1'b0;
        chk(burst_active, 1'b0, "R9 still normal");
        chk(pwm_enable, 1'b1, "R9 enable unchanged");
    endtask

    initial begin
        t_reset();
        t_ignored();
        t_entry();
        t_switching();
        t_trip();
        t_stop();
        t_exit();
        t_restart();
        t_exit_mid_pulse();
        go_burst();
        chk(burst_active, 1'b1, "R2 re-entry");
        t_exit();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule